// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

This block keeps a 32-bit count of elapsed seconds. A free-running prescaler in the slow 32.768 kHz domain divides that clock by 2^15 and produces one increment per second. Software reaches the block through a small register port in the system clock domain. Through it, software can load the count, program a 32-bit alarm value, read the live count and read a status word. The status word holds a sticky alarm flag, a load-busy bit and the low six count bits.

The count lives entirely in the slow domain and is cleared only by the cold power-on reset input. The warm system reset clears the alarm value and the flag, but leaves the count and the prescaler alone. A count load is posted: the bus side latches the value, hands it across with a toggle request/acknowledge, and shows busy until the slow domain has applied it. Reads of the count, and of the low-six field, sample a value that changes in another clock domain. Software must therefore read twice and accept a value only when two consecutive reads agree.

The register port is plain and has no back-pressure. A write strobe is taken in the cycle it is high. Read data is combinational on the address. Loads that arrive while busy is high are not retried by the block.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: The count rises by exactly one every 2^PRE_W slow-clock cycles (PRE_W defaults to 15, a divide by 32768). It wraps from 0xFFFFFFFF to 0.
- R2: A write to address 0 loads the count. Status bit 1 (busy) reads 1 from the cycle after the write until the slow domain has applied it. After busy falls, address 0 reads back the written value.
- R3: A write to address 0 while busy is 1 is dropped, and the earlier pending value is the one applied.
- R4: Loading the count clears the prescaler. The first increment after a load comes exactly 2^PRE_W slow-clock cycles after the load takes effect.
- R5: Address 1 is the alarm register, read/write, all 32 bits. Address 3 reads 0, and writes to it change nothing.
- R6: When the count takes on a new value equal to the alarm, whether by increment or by load, status bit 0 (alarm flag, also driven on `alarm_irq`) sets. The count keeps advancing past the match.
- R7: Writing address 2 with bit 0 = 1 clears the flag. A new match in the same cycle as a clear wins, and the flag ends up set.
- R8: The warm reset `sys_rst_n` clears the alarm register and the flag, and leaves the count running undisturbed.
- R9: The cold reset `por_n` clears the count, the prescaler, the flag and busy.
- R10: Status bits 13:8 show count bits 5:0, and the other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (bus) clock |
| sys_rst_n | input | 1 | Warm reset, active low |
| por_n | input | 1 | Cold power-on reset, active low, clears everything |
| rtc_clk | input | 1 | 32.768 kHz slow clock |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 2 | Register select: 0 count, 1 alarm, 2 status, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| alarm_irq | output | 1 | Sticky alarm flag |

## Verification
Two events can land in the same system cycle: a clear write to the status register, and the arrival of a new match in the bus domain. The bench provokes the collision by loading a count two seconds short of the alarm. It then writes the clear bit on every cycle until the count has passed the alarm. Set priority is judged by seeing the flag high at some cycle during that burst. Once the burst stops, the flag must read as cleared. A design that let the clear win would never show the flag at all.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_ALARM  = 2'd1,
    REG_STATUS = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  localparam int ST_FLAG_BIT = 0;
  localparam int ST_BUSY_BIT = 1;
  localparam int ST_LO_LSB   = 8;
  localparam int LO_W        = 6;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else          div_q <= div_q + 1'b1;
  end

  assign tick = &div_q;
endmodule

// File: rtl/rtc_toggle_sync.sv
module rtc_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic level
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= tog_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], tog_in};
      end
    end
  endgenerate

  assign level = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] cnt,
  output logic             match_tog
);
  logic [CNT_W-1:0] nxt;
  logic             upd;

  always_comb begin
    nxt = cnt;
    upd = 1'b0;
    if (load) begin
      nxt = load_val;
      upd = 1'b1;
    end else if (tick) begin
      nxt = cnt + 1'b1;
      upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      match_tog <= 1'b0;
    end else begin
      cnt <= nxt;
      if (upd && (nxt == alarm)) match_tog <= ~match_tog;
    end
  end
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm #(
  parameter int PRE_W     = 15,
  parameter int CNT_W     = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             por_n,
  input  logic             rtc_clk,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             alarm_irq
);
  import rtc_pkg::*;

  localparam int PAD_HI = CNT_W - ST_LO_LSB - LO_W;
  localparam int PAD_MID = ST_LO_LSB - 2;

  logic             warm_n;
  logic             cnt_wr_go, clr_wr, alarm_wr;
  logic             busy, ack_lvl;
  logic             req_tog;
  logic [CNT_W-1:0] hold_val;
  logic [CNT_W-1:0] alarm_q;
  logic             irq;
  logic             req_lvl, req_seen, load;
  logic             tick;
  logic [CNT_W-1:0] sec_cnt;
  logic             match_tog, m_lvl, m_seen, match_set;
  reg_sel_e         sel;

  assign warm_n    = sys_rst_n & por_n;
  assign sel       = reg_sel_e'(bus_addr);
  assign busy      = req_tog ^ ack_lvl;
  assign cnt_wr_go = bus_wr && (sel == REG_COUNT) && !busy;
  assign alarm_wr  = bus_wr && (sel == REG_ALARM);
  assign clr_wr    = bus_wr && (sel == REG_STATUS) && bus_wdata[ST_FLAG_BIT];

  // load request side, cold reset only so a warm reset cannot fake a request
  always_ff @(posedge sys_clk or negedge por_n) begin
    if (!por_n) begin
      req_tog  <= 1'b0;
      hold_val <= '0;
    end else if (cnt_wr_go) begin
      req_tog  <= ~req_tog;
      hold_val <= bus_wdata;
    end
  end

  always_ff @(posedge sys_clk or negedge warm_n) begin
    if (!warm_n)       alarm_q <= '0;
    else if (alarm_wr) alarm_q <= bus_wdata;
  end

  // slow domain: request detect, prescaler, counter
  rtc_toggle_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk(rtc_clk), .rst_n(por_n), .tog_in(req_tog), .level(req_lvl)
  );

  always_ff @(posedge rtc_clk or negedge por_n) begin
    if (!por_n) req_seen <= 1'b0;
    else        req_seen <= req_lvl;
  end

  assign load = req_lvl ^ req_seen;

  rtc_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(rtc_clk), .rst_n(por_n), .clr(load), .tick(tick)
  );

  rtc_sec_core #(.CNT_W(CNT_W)) u_core (
    .clk(rtc_clk), .rst_n(por_n), .load(load), .load_val(hold_val),
    .tick(tick), .alarm(alarm_q), .cnt(sec_cnt), .match_tog(match_tog)
  );

  // back into the bus domain: acknowledge and match event
  rtc_toggle_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk(sys_clk), .rst_n(por_n), .tog_in(req_seen), .level(ack_lvl)
  );

  rtc_toggle_sync #(.STAGES(SYNC_DEPTH)) u_match_sync (
    .clk(sys_clk), .rst_n(por_n), .tog_in(match_tog), .level(m_lvl)
  );

  always_ff @(posedge sys_clk or negedge por_n) begin
    if (!por_n) m_seen <= 1'b0;
    else        m_seen <= m_lvl;
  end

  assign match_set = m_lvl ^ m_seen;

  always_ff @(posedge sys_clk or negedge warm_n) begin
    if (!warm_n)        irq <= 1'b0;
    else if (match_set) irq <= 1'b1;
    else if (clr_wr)    irq <= 1'b0;
  end

  assign alarm_irq = irq;

  always_comb begin
    unique case (sel)
      REG_COUNT:  bus_rdata = sec_cnt;
      REG_ALARM:  bus_rdata = alarm_q;
      REG_STATUS: bus_rdata = {{PAD_HI{1'b0}}, sec_cnt[LO_W-1:0],
                               {PAD_MID{1'b0}}, busy, irq};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_seconds_alarm_chk.sv
module rtc_seconds_alarm_chk #(
  parameter int CNT_W = 32
) (
  input logic             sys_clk,
  input logic             rtc_clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             cnt_wr_go,
  input logic             busy,
  input logic [CNT_W-1:0] hold_val,
  input logic             irq,
  input logic             match_set,
  input logic             clr_wr,
  input logic             load,
  input logic [CNT_W-1:0] sec_cnt
);
  // R2: an accepted load shows busy on the next bus cycle
  p_busy_after_load_r2: assert property (@(posedge sys_clk) disable iff (!(sys_rst_n && por_n))
    cnt_wr_go |=> busy);

  // R3: the pending value cannot be replaced while busy
  p_hold_frozen_r3: assert property (@(posedge sys_clk) disable iff (!por_n)
    busy |=> $stable(hold_val));

  // R1: without a load the count holds or steps by one
  p_single_step_r1: assert property (@(posedge rtc_clk) disable iff (!por_n)
    !load |=> (sec_cnt == $past(sec_cnt)) || (sec_cnt == $past(sec_cnt) + 1'b1));

  // R2: a load lands the pending value in the count
  p_load_applied_r2: assert property (@(posedge rtc_clk) disable iff (!por_n)
    load |=> sec_cnt == $past(hold_val));

  // R6: the flag holds until a clear write
  p_flag_sticky_r6: assert property (@(posedge sys_clk) disable iff (!(sys_rst_n && por_n))
    irq && !clr_wr |=> irq);

  // R7: a match event always leaves the flag set, even against a clear
  p_set_wins_r7: assert property (@(posedge sys_clk) disable iff (!(sys_rst_n && por_n))
    match_set |=> irq);

  // R6: the flag only rises from a match event
  p_rise_cause_r6: assert property (@(posedge sys_clk) disable iff (!(sys_rst_n && por_n))
    $rose(irq) |-> $past(match_set));
endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .sys_clk(sys_clk), .rtc_clk(rtc_clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
  .cnt_wr_go(cnt_wr_go), .busy(busy), .hold_val(hold_val), .irq(irq),
  .match_set(match_set), .clr_wr(clr_wr), .load(load), .sec_cnt(sec_cnt)
);

// File: tb/sim_rtc_seconds_alarm.sv
`timescale 1ns/1ps
module sim_rtc_seconds_alarm;
  localparam int PRE_W = 3;
  localparam int SEC   = 1 << PRE_W;

  logic        sys_clk = 0, rtc_clk = 0;
  logic        sys_rst_n = 0, por_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        alarm_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 sys_clk = ~sys_clk;
  always #35 rtc_clk = ~rtc_clk;

  rtc_seconds_alarm #(.PRE_W(PRE_W)) u0 (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .por_n(por_n), .rtc_clk(rtc_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
  );

  // {is_read, addr, data}; reads compare against data
  localparam logic [34:0] VECS [0:7] = '{
    {1'b0, 2'd1, 32'hA5A5_0F0F},
    {1'b1, 2'd1, 32'hA5A5_0F0F},
    {1'b0, 2'd1, 32'h0000_0000},
    {1'b1, 2'd1, 32'h0000_0000},
    {1'b0, 2'd1, 32'hFFFF_FFFF},
    {1'b0, 2'd3, 32'h1234_5678},
    {1'b1, 2'd3, 32'h0000_0000},
    {1'b1, 2'd1, 32'hFFFF_FFFF}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge sys_clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge sys_clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge sys_clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic read_stable(input logic [1:0] a, output logic [31:0] v);
    logic [31:0] x, y;
    bus_read(a, x);
    for (int i = 0; i < 20; i++) begin
      bus_read(a, y);
      if (x == y) break;
      x = y;
    end
    v = y;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      bus_read(2'd2, s);
      if (!s[1]) break;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c, s, s2, cur;
    int k;
    bit seen;

    repeat (5) @(negedge sys_clk);
    por_n = 1; sys_rst_n = 1;

    // reset state
    read_stable(2'd0, v); check(v == 0, "R9 count after cold reset", v, 0);
    bus_read(2'd2, v);    check(v[1:0] == 0, "R9 busy/flag after cold reset", v[1:0], 0);
    bus_read(2'd1, v);    check(v == 0, "R8 alarm reset value", v, 0);

    // register vectors
    for (int i = 0; i < 8; i++) begin
      if (VECS[i][34]) begin
        bus_read(VECS[i][33:32], v);
        check(v == VECS[i][31:0], "R5 register vector", v, VECS[i][31:0]);
      end else begin
        bus_write(VECS[i][33:32], VECS[i][31:0]);
      end
    end

    // R2 load with busy
    bus_write(2'd0, 32'h1234_5670);
    bus_read(2'd2, v); check(v[1] == 1, "R2 busy after load", v[1], 1);
    wait_idle();
    read_stable(2'd0, v); check(v == 32'h1234_5670, "R2 count readback", v, 32'h1234_5670);

    // R3 second load while busy is dropped
    bus_write(2'd0, 32'h0000_0A00);
    bus_write(2'd0, 32'h0000_0B00);
    wait_idle();
    read_stable(2'd0, v); check(v == 32'h0000_0A00, "R3 dropped load", v, 32'h0000_0A00);

    // R4 / R1 timing measured on the low-six field at slow-clock negedges
    read_stable(2'd0, cur);
    c = cur + 32'd20;
    bus_write(2'd0, c);
    bus_addr = 2'd2;
    k = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge rtc_clk);
      if (bus_rdata[13:8] == c[5:0]) break;
    end
    for (int i = 0; i < 100; i++) begin
      @(negedge rtc_clk); k++;
      if (bus_rdata[13:8] != c[5:0]) break;
    end
    check(k == SEC, "R4 first step after load", k, SEC);
    check(bus_rdata[13:8] == 6'(c[5:0] + 6'd1), "R1 step value", bus_rdata[13:8], 6'(c[5:0] + 6'd1));
    s = {26'd0, bus_rdata[13:8]}; k = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge rtc_clk); k++;
      if (bus_rdata[13:8] != s[5:0]) break;
    end
    check(k == SEC, "R1 steady interval", k, SEC);

    // R10 low-six field agrees with the count
    for (int i = 0; i < 10; i++) begin
      read_stable(2'd2, s); read_stable(2'd0, c); read_stable(2'd2, s2);
      if (s == s2) break;
    end
    check(s[13:8] == c[5:0], "R10 low six bits", s[13:8], c[5:0]);
    check(s[31:14] == 0 && s[7:2] == 0, "R10 zero pad", s, 0);

    // R6 match by increment, keeps counting
    bus_write(2'd1, 32'h0000_0102);
    bus_write(2'd0, 32'h0000_0100);
    wait_idle();
    bus_write(2'd2, 32'd1);
    for (int i = 0; i < 300; i++) begin
      @(negedge sys_clk);
      if (alarm_irq) break;
    end
    check(alarm_irq == 1, "R6 flag on increment match", alarm_irq, 1);
    repeat (40) @(negedge rtc_clk);
    read_stable(2'd0, v); check(v > 32'h102, "R6 counting past match", v, 32'h103);
    bus_read(2'd2, v); check(v[0] == 1, "R6 flag sticky", v[0], 1);
    bus_write(2'd2, 32'd1);
    bus_read(2'd2, v); check(v[0] == 0, "R7 clear write", v[0], 0);

    // R6 match by load
    bus_write(2'd1, 32'h0000_5000);
    bus_write(2'd0, 32'h0000_5000);
    wait_idle();
    repeat (6) @(negedge sys_clk);
    bus_read(2'd2, v); check(v[0] == 1, "R6 flag on load match", v[0], 1);

    // R7 set beats clear in the same cycle
    bus_write(2'd1, 32'h0000_7002);
    bus_write(2'd0, 32'h0000_7000);
    wait_idle();
    seen = 0;
    for (int i = 0; i < 160; i++) begin
      @(negedge sys_clk);
      bus_wr = 1; bus_addr = 2'd2; bus_wdata = 32'd1;
      if (i > 2 && alarm_irq) seen = 1;
    end
    @(negedge sys_clk); bus_wr = 0;
    check(seen == 1, "R7 set priority over clear", seen, 1);
    bus_read(2'd2, v); check(v[0] == 0, "R7 cleared after burst", v[0], 0);

    // R8 warm reset
    bus_write(2'd0, 32'hABCD_0000);
    wait_idle();
    bus_write(2'd1, 32'h0000_0777);
    bus_write(2'd1, 32'hABCD_0000);
    @(negedge sys_clk); sys_rst_n = 0;
    repeat (5) @(negedge sys_clk); sys_rst_n = 1;
    bus_read(2'd1, v); check(v == 0, "R8 alarm cleared", v, 0);
    bus_read(2'd2, v); check(v[0] == 0, "R8 flag cleared", v[0], 0);
    read_stable(2'd0, v);
    check(v >= 32'hABCD_0000 && v <= 32'hABCD_0003, "R8 count kept", v, 32'hABCD_0000);

    // R1 wrap, with the alarm at 0 (R6)
    bus_write(2'd0, 32'hFFFF_FFFE);
    wait_idle();
    repeat (20) @(negedge rtc_clk);
    read_stable(2'd0, v); check(v < 32'd3, "R1 wrap to zero", v, 0);
    bus_read(2'd2, v); check(v[0] == 1, "R6 match at wrap", v[0], 1);

    // R9 cold reset
    @(negedge sys_clk); por_n = 0;
    repeat (4) @(negedge sys_clk); por_n = 1;
    read_stable(2'd0, v); check(v == 0, "R9 count cleared", v, 0);
    bus_read(2'd2, v); check(v[1:0] == 0, "R9 flag and busy cleared", v[1:0], 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule